// File: doc/BRIEF.md
# 64-bit Sparse-Opcode Arithmetic Unit

This block is the arithmetic core of a single-cycle processor datapath. It takes two 64-bit operands and a 3-bit operation code, and returns one 64-bit result in the same cycle. It has no clock and no stored state. The five supported operations are addition, subtraction, multiplication, logical left shift and logical right shift. The datapath reuses the add and subtract codes to form load, store and branch-target addresses.

The operation code map is fixed and sparse. Codes 011, 110 and 111 have no operation assigned and force the result to zero. Inside the block, a small decoder turns the operation code into one-hot select strobes. A datapath module computes all the candidate results and merges them under those strobes.

Top module: `alu64_exec`

## Requirements
- R1: Code 000 gives opA + opB, truncated to 64 bits (wraps modulo 2^64).
- R2: Code 001 gives opA - opB, truncated to 64 bits (wraps modulo 2^64).
- R3: Code 010 gives the low 64 bits of the full 128-bit product opA * opB.
- R4: Code 100 gives opA shifted left by the shift amount. Vacated low bits are filled with zeros.
- R5: Code 101 gives opA shifted right by the shift amount. Vacated high bits are filled with zeros.
- R6: For both shift codes, the shift amount is opB[5:0]. Bits opB[63:6] have no effect on the result.
- R7: Codes 011, 110 and 111 give a result of zero for any operand values.
- R8: The result depends only on the present inputs. It follows an input change with no clock edge in between.
- R9: The decoder raises at most one select strobe at any time, and raises none for the three unused codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand; the value that is shifted |
| opB | input | 64 | Second operand; its low 6 bits are the shift amount |
| opSel | input | 3 | Operation code |
| result | output | 64 | Combinational result |

## Verification
Two cases are hard to reach from the ports. The first is showing that the upper bits of opB really are ignored by the shifts. The stimulus sets those bits together with a small low field, for example a shift amount of 0x44 that must act as 4, and 0x40 that must act as 0. The expected value then differs visibly from what a full-width shift amount would produce. The second is multiply truncation. Operands are chosen so that the true product lies entirely above bit 63, or wraps through it, so a result formed from the wrong half of the product shows up at once.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101
  } aluOp_e;

  // One-hot select strobes from the decoder to the datapath
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selMul;
    logic selShl;
    logic selShr;
  } aluStrobes_t;

endpackage

// File: rtl/alu64_ctrl.sv
module alu64_ctrl
  import alu64_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '0;
    case (opSel)
      OP_ADD:  strobes.selAdd = 1'b1;
      OP_SUB:  strobes.selSub = 1'b1;
      OP_MUL:  strobes.selMul = 1'b1;
      OP_SHL:  strobes.selShl = 1'b1;
      OP_SHR:  strobes.selShr = 1'b1;
      default: strobes = '0;
    endcase
  end

  // R9: never more than one strobe, none for the unused codes
  always_comb begin
    a_r9_strobe_onehot: assert ($onehot0(strobes))
      else $error("decoder raised several strobes");
    if (opSel == 3'b011 || opSel == 3'b110 || opSel == 3'b111)
      a_r9_unused_no_strobe: assert (strobes == '0)
        else $error("strobe raised for unused code");
  end

endmodule

// File: rtl/alu64_dp.sv
module alu64_dp
  import alu64_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result
);

  localparam int SHW = $clog2(WIDTH);

  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] carryIn;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] prodVal;
  logic [SHW-1:0]   shAmt;
  logic [WIDTH-1:0] shlVal;
  logic [WIDTH-1:0] shrVal;

  // Shared adder: subtraction is opA + ~opB + 1
  assign addend  = strobes.selSub ? ~opB : opB;
  assign carryIn = {{(WIDTH-1){1'b0}}, strobes.selSub};
  assign sumVal  = opA + addend + carryIn;

  // Low half of the product only
  assign prodVal = opA * opB;

  assign shAmt  = opB[SHW-1:0];
  assign shlVal = opA << shAmt;
  assign shrVal = opA >> shAmt;

  // AND-OR merge under the one-hot strobes; no strobe gives zero
  always_comb begin
    result = '0;
    result = result | ({WIDTH{strobes.selAdd | strobes.selSub}} & sumVal);
    result = result | ({WIDTH{strobes.selMul}} & prodVal);
    result = result | ({WIDTH{strobes.selShl}} & shlVal);
    result = result | ({WIDTH{strobes.selShr}} & shrVal);
  end

  // R7: with no strobe raised the output is zero
  always_comb begin
    if (strobes == '0)
      a_r7_idle_zero: assert (result == '0)
        else $error("nonzero result with no strobe");
    // R4: left shift leaves the low shAmt bits clear
    if (strobes.selShl && shAmt != '0)
      a_r4_shl_lowzero: assert (result[0] == 1'b0)
        else $error("left shift filled bit 0");
    // R5: right shift leaves the top bit clear for nonzero amounts
    if (strobes.selShr && shAmt != '0)
      a_r5_shr_topzero: assert (result[WIDTH-1] == 1'b0)
        else $error("right shift filled top bit");
  end

endmodule

// File: rtl/alu64_exec.sv
module alu64_exec
  import alu64_pkg::*;
(
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [2:0]  opSel,
  output logic [63:0] result
);

  aluStrobes_t strobes;

  alu64_ctrl ctrl_i (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu64_dp #(.WIDTH(64)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result)
  );

  // R1/R2: a zero second operand passes opA through add and subtract
  always_comb begin
    if ((opSel == 3'b000 || opSel == 3'b001) && opB == '0)
      a_r1_r2_identity: assert (result == opA)
        else $error("add/sub with zero operand altered opA");
  end

endmodule

// File: tb/alu64_exec_tb.sv
module alu64_exec_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [63:0] opA, opB, result;
  logic [2:0]  opSel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  alu64_exec dut_i (
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .result (result)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd1, 8'd1},                    // R1 wrap
    '{3'b000, 64'h1234, 64'h1000, 64'h2234, 8'd1},                             // R1
    '{3'b001, 64'd5, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 8'd2},                    // R2 wrap
    '{3'b001, 64'h100, 64'h1, 64'hFF, 8'd2},                                   // R2
    '{3'b010, 64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 8'd3},                  // R3 product above bit 63
    '{3'b010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'hFFFF_FFFF_FFFF_FFFD, 8'd3},  // R3 wrap
    '{3'b010, 64'd7, 64'd6, 64'd42, 8'd3},                                     // R3
    '{3'b100, 64'd1, 64'd63, 64'h8000_0000_0000_0000, 8'd4},                   // R4
    '{3'b100, 64'hFF, 64'd8, 64'hFF00, 8'd4},                                  // R4
    '{3'b100, 64'hF0, 64'h44, 64'hF00, 8'd6},                                  // R6 0x44 acts as 4
    '{3'b101, 64'h8000_0000_0000_0000, 64'd63, 64'd1, 8'd5},                   // R5
    '{3'b101, 64'hF000_0000_0000_0000, 64'd4, 64'h0F00_0000_0000_0000, 8'd5},  // R5 zero fill
    '{3'b101, 64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6}, // R6 0x40 acts as 0
    '{3'b011, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd7},  // R7
    '{3'b110, 64'h1234_5678, 64'd3, 64'd0, 8'd7},                              // R7
    '{3'b111, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 8'd7}                     // R7
  };

  task automatic check(input logic [63:0] exp, input int req, input string what);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, result, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog expired: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // reset-like idle state: all inputs zero, add code -> zero (R1)
    opA = '0; opB = '0; opSel = 3'b000;
    @(negedge clk);
    check(64'd0, 1, "idle zero inputs");

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      opSel = VECS[i].op; opA = VECS[i].a; opB = VECS[i].b;
      @(negedge clk);
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R8: result follows inputs with no clock edge in between
    @(posedge clk);
    #1;
    opSel = 3'b000; opA = 64'd10; opB = 64'd20;
    #1;
    check(64'd30, 8, "follows inputs before edge");
    opSel = 3'b001;
    #1;
    check(64'hFFFF_FFFF_FFFF_FFF6, 8, "recomputes on opcode change");

    // R6: upper opB bits ignored across a full sweep of high patterns
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      opSel = 3'b100; opA = 64'h3; opB = {58'h155 << k, 6'd2};
      @(negedge clk);
      check(64'hC, 6, "shl high bits of opB ignored");
    end

    // R4/R5: shift of zero leaves operand unchanged
    @(posedge clk);
    opSel = 3'b101; opA = 64'hDEAD_BEEF_0000_0001; opB = 64'd0;
    @(negedge clk);
    check(64'hDEAD_BEEF_0000_0001, 5, "shr by zero");
    @(posedge clk);
    opSel = 3'b100;
    @(negedge clk);
    check(64'hDEAD_BEEF_0000_0001, 4, "shl by zero");

    // R9 seen at ports: each unused code gives zero, next valid code works
    @(posedge clk);
    opSel = 3'b110; opA = 64'd9; opB = 64'd9;
    @(negedge clk);
    check(64'd0, 9, "unused code selects nothing");
    @(posedge clk);
    opSel = 3'b010;
    @(negedge clk);
    check(64'd81, 9, "valid code after unused");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule